// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block sits between the execute stage of an 8-bit processor core and its memory/stack port. At every instruction boundary the core pulses `boundary_i`, and the sequencer decides whether to take a non-maskable interrupt, a maskable interrupt, or nothing. A non-maskable request is latched on a rising edge of `nmi_i` and always takes precedence over a maskable one. A maskable request is taken only when the request line is high, the enable flip-flop is set, and the instruction that just completed did not raise the skip flag.

Once an interrupt is accepted, the sequencer does the following:
- It stalls the core through `busy_o`.
- For maskable requests, it holds an acknowledge phase whose length depends on the mode. During this phase it collects device bytes from the data bus.
- It pushes the return PC two bytes deep onto the stack.
- It resolves the new PC: a fixed vector, a table lookup through the I register, or a restore of the original PC with four captured opcode bytes for an external decoder.
- It publishes the results for one cycle.

A halted core that sees no interrupt at a boundary is told to run a NOP fetch without advancing its PC. The block also keeps the refresh register R.

Top module: `irq_response_seq`

## Requirements
- R1: After synchronous reset `busy_o`, `iack_o`, `mem_req_o`, `pc_wr_o`, `sp_wr_o`, `wz_wr_o` and `op0_vld_o` are 0 and `r_o` is 0x00.
- R2: A decision is made only in a cycle with `boundary_i` high while the sequencer is idle. A maskable request is accepted only if `int_i`=1, `ie_i`=1 and `skip_irq_i`=0, and `ie_clr_o` pulses in that same cycle. Otherwise no stack write and no PC write follow.
- R3: A rising edge of `nmi_i` is latched. At the next boundary it is taken before any maskable request, whatever `ie_i` is, and the new PC is 0x0066. It has no acknowledge phase, no WZ write and no `ie_clr_o`. A maskable request still pending is taken at a later boundary.
- R4: The PC push writes PC[15:8] to SP-1 first and then PC[7:0] to SP-2. Each memory request is held with a stable address until `mem_ack_i`. `sp_wr_o` reports SP-2.
- R5: Mode 1 (`im_i`=1), and the unused code `im_i`=3, vector to 0x0038.
- R6: Mode 2 (`im_i`=2) forms pointer P = {I, b}. Here b is `dbus_i` sampled in the first acknowledge cycle if `dbus_vld_i`=1, and 0x00 otherwise. The block reads the low byte at P, then the high byte at P+1 (16-bit wrap), and the word read is the new PC.
- R7: Mode 0 (`im_i`=0) samples one byte in each of the first four acknowledge cycles, using 0x00 when `dbus_vld_i`=0. Byte k appears in `op0_bytes_o`[8k+7:8k]. After the push, `pc_wr_o` restores the original PC, with `op0_vld_o` high in the same cycle.
- R8: After each maskable vectoring `wz_wr_o` pulses together with `pc_wr_o`, with `wz_o` equal to the new PC. The sequencer is idle in the following cycle.
- R9: `iack_o` is high for exactly ACK_M0/ACK_M1/ACK_M2 consecutive cycles (defaults 6/7/8) for modes 0/1/2. It starts in the cycle after acceptance.
- R10: If `halted_i`=1 and no interrupt is taken at a boundary, `halt_nop_o` pulses and no PC write follows. If an interrupt is taken while halted, `halt_clr_o` pulses in the acceptance cycle.
- R11: Each `boundary_i` adds 1 to R[6:0] modulo 128 and keeps R[7]. A load through `r_wr_i` replaces R and wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction finished, interrupt sampling point |
| skip_irq_i | input | 1 | Completed instruction suppresses maskable acceptance |
| nmi_i | input | 1 | Non-maskable request (edge latched) |
| int_i | input | 1 | Maskable request level |
| ie_i | input | 1 | Interrupt enable flip-flop |
| im_i | input | 2 | Interrupt mode |
| i_reg_i | input | 8 | Vector table page register |
| pc_i | input | 16 | Current PC |
| sp_i | input | 16 | Current stack pointer |
| halted_i | input | 1 | Core is in the halted state |
| dbus_i | input | 8 | Device byte on the data bus |
| dbus_vld_i | input | 1 | Device is driving a byte |
| r_wr_i | input | 1 | Load R |
| r_wdata_i | input | 8 | Value loaded into R |
| mem_rdata_i | input | 8 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory access complete |
| busy_o | output | 1 | Sequence in progress, core stalled |
| iack_o | output | 1 | Interrupt acknowledge phase |
| ie_clr_o | output | 1 | Clear enable flip-flop |
| halt_clr_o | output | 1 | Release halt |
| halt_nop_o | output | 1 | Run NOP fetch without advancing PC |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| sp_wr_o | output | 1 | Stack pointer update strobe |
| sp_new_o | output | 16 | New stack pointer |
| pc_wr_o | output | 1 | PC update strobe |
| pc_new_o | output | 16 | New PC |
| wz_wr_o | output | 1 | WZ update strobe |
| wz_o | output | 16 | WZ value |
| op0_vld_o | output | 1 | Mode-0 opcode bytes ready |
| op0_bytes_o | output | 32 | Captured mode-0 opcode bytes |
| r_o | output | 8 | Refresh register R |

## Verification
The bench targets the following corner cases:
- A simultaneous non-maskable and maskable request. A design with the priority reversed would vector to 0x0038 and clear the enable instead of going to 0x0066.
- The skip flag and the disabled-enable case. A wrong gate there would produce a stack write that should never happen.
- The mode-2 pointer 0xFFFF, which must wrap to 0x0000 for its high byte, and the missing device byte, which must read as 0x00.
- A mode-0 instruction shorter than four bytes. Without padding, stale bus data would leak into the upper bytes.
- The R register at 0xFF and 0x7F. An increment that carries into bit 7 is caught there, and so is a load that loses against a coincident increment.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int AW     = 16;
    localparam int DW     = 8;
    localparam int NBYTE0 = 4;

    localparam logic [AW-1:0] NMI_VEC = 16'h0066;
    localparam logic [AW-1:0] M1_VEC  = 16'h0038;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK,
        S_PUSH_H,
        S_PUSH_L,
        S_RD_L,
        S_RD_H,
        S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        K_NMI = 2'd0,
        K_M0  = 2'd1,
        K_M1  = 2'd2,
        K_M2  = 2'd3
    } irq_kind_e;

    typedef struct packed {
        logic      take;
        irq_kind_e kind;
    } arb_res_t;

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mem_cmd_t;

    function automatic irq_kind_e kind_of_mode(input logic [1:0] im);
        case (im)
            2'd0:    return K_M0;
            2'd2:    return K_M2;
            default: return K_M1;
        endcase
    endfunction

    function automatic logic [DW-1:0] refresh_step(input logic [DW-1:0] r);
        logic [DW-2:0] low;
        low = r[DW-2:0] + 1'b1;
        return {r[DW-1], low};
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_i,
    input  logic       nmi_i,
    input  logic       int_i,
    input  logic       ie_i,
    input  logic       skip_i,
    input  logic [1:0] im_i,
    input  logic       halted_i,
    output arb_res_t   res_o,
    output logic       ie_clr_o,
    output logic       halt_clr_o,
    output logic       halt_nop_o
);

    logic nmi_prev_q;
    logic nmi_pend_q;
    logic nmi_edge;
    logic take_nmi;
    logic take_int;

    assign nmi_edge = nmi_i & ~nmi_prev_q;
    assign take_nmi = sample_i & nmi_pend_q;
    assign take_int = sample_i & ~nmi_pend_q & int_i & ie_i & ~skip_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_i;
            nmi_pend_q <= (nmi_pend_q & ~take_nmi) | nmi_edge;
        end
    end

    always_comb begin
        res_o.take = take_nmi | take_int;
        res_o.kind = take_nmi ? K_NMI : kind_of_mode(im_i);
    end

    assign ie_clr_o   = take_int;
    assign halt_clr_o = res_o.take & halted_i;
    assign halt_nop_o = sample_i & ~res_o.take & halted_i;

    // R3
    nmi_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_i && !nmi_prev_q) |=> nmi_pend_q);

endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer
    import irq_seq_pkg::*;
#(
    parameter int LEN0 = 6,
    parameter int LEN1 = 7,
    parameter int LEN2 = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  irq_kind_e            kind_i,
    input  logic [DW-1:0]        dbus_i,
    input  logic                 dbus_vld_i,
    output logic                 active_o,
    output logic                 done_o,
    output logic [NBYTE0*DW-1:0] bytes_o,
    output logic [DW-1:0]        vec_o
);

    localparam int LMAX01 = (LEN0 > LEN1) ? LEN0 : LEN1;
    localparam int LMAX   = (LMAX01 > LEN2) ? LMAX01 : LEN2;
    localparam int CW     = $clog2(LMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;
    logic [CW-1:0] last_sel;
    logic          active_q;
    logic [DW-1:0] vec_q;
    logic [DW-1:0] dbyte;

    assign dbyte = dbus_vld_i ? dbus_i : '0;

    always_comb begin
        case (kind_i)
            K_M0:    last_sel = CW'(LEN0 - 1);
            K_M2:    last_sel = CW'(LEN2 - 1);
            default: last_sel = CW'(LEN1 - 1);
        endcase
    end

    assign done_o   = active_q && (cnt_q == last_q);
    assign active_o = active_q;
    assign vec_o    = vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            last_q   <= '0;
            vec_q    <= '0;
        end else begin
            if (start_i) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                last_q   <= last_sel;
            end else if (active_q) begin
                if (done_o) active_q <= 1'b0;
                else        cnt_q    <= cnt_q + 1'b1;
            end
            if (active_q && cnt_q == '0) vec_q <= dbyte;
        end
    end

    for (genvar g = 0; g < NBYTE0; g++) begin : g_cap
        logic [DW-1:0] b_q;
        always_ff @(posedge clk) begin
            if (rst || start_i)                       b_q <= '0;
            else if (active_q && cnt_q == CW'(g))     b_q <= dbyte;
        end
        assign bytes_o[g*DW +: DW] = b_q;
    end

    // R9
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !done_o) |=> active_q);

endmodule

// File: rtl/irq_refresh.sv
module irq_refresh
    import irq_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] r_o
);

    logic [DW-1:0] r_q;

    always_ff @(posedge clk) begin
        if (rst)         r_q <= '0;
        else if (wr_i)   r_q <= wdata_i;
        else if (step_i) r_q <= refresh_step(r_q);
    end

    assign r_o = r_q;

    // R11
    r_bit7_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !wr_i) |=> (r_q[DW-1] == $past(r_q[DW-1])) &&
                              (r_q[DW-2:0] == $past(r_q[DW-2:0]) + 1'b1));

endmodule

// File: rtl/irq_response_seq.sv
module irq_response_seq
    import irq_seq_pkg::*;
#(
    parameter int ACK_M0 = 6,
    parameter int ACK_M1 = 7,
    parameter int ACK_M2 = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary_i,
    input  logic        skip_irq_i,
    input  logic        nmi_i,
    input  logic        int_i,
    input  logic        ie_i,
    input  logic [1:0]  im_i,
    input  logic [7:0]  i_reg_i,
    input  logic [15:0] pc_i,
    input  logic [15:0] sp_i,
    input  logic        halted_i,
    input  logic [7:0]  dbus_i,
    input  logic        dbus_vld_i,
    input  logic        r_wr_i,
    input  logic [7:0]  r_wdata_i,
    input  logic [7:0]  mem_rdata_i,
    input  logic        mem_ack_i,
    output logic        busy_o,
    output logic        iack_o,
    output logic        ie_clr_o,
    output logic        halt_clr_o,
    output logic        halt_nop_o,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    output logic        sp_wr_o,
    output logic [15:0] sp_new_o,
    output logic        pc_wr_o,
    output logic [15:0] pc_new_o,
    output logic        wz_wr_o,
    output logic [15:0] wz_o,
    output logic        op0_vld_o,
    output logic [31:0] op0_bytes_o,
    output logic [7:0]  r_o
);

    seq_state_e    state_q, state_d;
    irq_kind_e     kind_q;
    logic [AW-1:0] pc_q, sp_q, tgt_q;
    logic [DW-1:0] i_q, lo_q;
    arb_res_t      arb;
    logic          idle;
    logic          ack_done;
    logic [DW-1:0] ack_vec;
    logic [AW-1:0] ptr, ptr1;
    mem_cmd_t      cmd;

    assign idle = (state_q == S_IDLE);

    irq_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .sample_i  (boundary_i & idle),
        .nmi_i     (nmi_i),
        .int_i     (int_i),
        .ie_i      (ie_i),
        .skip_i    (skip_irq_i),
        .im_i      (im_i),
        .halted_i  (halted_i),
        .res_o     (arb),
        .ie_clr_o  (ie_clr_o),
        .halt_clr_o(halt_clr_o),
        .halt_nop_o(halt_nop_o)
    );

    irq_ack_timer #(
        .LEN0(ACK_M0),
        .LEN1(ACK_M1),
        .LEN2(ACK_M2)
    ) u_ack (
        .clk       (clk),
        .rst       (rst),
        .start_i   (arb.take && arb.kind != K_NMI),
        .kind_i    (arb.kind),
        .dbus_i    (dbus_i),
        .dbus_vld_i(dbus_vld_i),
        .active_o  (iack_o),
        .done_o    (ack_done),
        .bytes_o   (op0_bytes_o),
        .vec_o     (ack_vec)
    );

    irq_refresh u_r (
        .clk    (clk),
        .rst    (rst),
        .step_i (boundary_i),
        .wr_i   (r_wr_i),
        .wdata_i(r_wdata_i),
        .r_o    (r_o)
    );

    assign ptr  = {i_q, ack_vec};
    assign ptr1 = ptr + 16'd1;

    always_comb begin
        cmd = '0;
        case (state_q)
            S_PUSH_H: begin
                cmd.req = 1'b1; cmd.we = 1'b1;
                cmd.addr = sp_q - 16'd1; cmd.wdata = pc_q[15:8];
            end
            S_PUSH_L: begin
                cmd.req = 1'b1; cmd.we = 1'b1;
                cmd.addr = sp_q - 16'd2; cmd.wdata = pc_q[7:0];
            end
            S_RD_L: begin
                cmd.req = 1'b1; cmd.addr = ptr;
            end
            S_RD_H: begin
                cmd.req = 1'b1; cmd.addr = ptr1;
            end
            default: cmd = '0;
        endcase
    end

    assign mem_req_o   = cmd.req;
    assign mem_we_o    = cmd.we;
    assign mem_addr_o  = cmd.addr;
    assign mem_wdata_o = cmd.wdata;

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:   if (arb.take) state_d = (arb.kind == K_NMI) ? S_PUSH_H : S_ACK;
            S_ACK:    if (ack_done) state_d = S_PUSH_H;
            S_PUSH_H: if (mem_ack_i) state_d = S_PUSH_L;
            S_PUSH_L: if (mem_ack_i) state_d = (kind_q == K_M2) ? S_RD_L : S_FIN;
            S_RD_L:   if (mem_ack_i) state_d = S_RD_H;
            S_RD_H:   if (mem_ack_i) state_d = S_FIN;
            S_FIN:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            kind_q  <= K_NMI;
            pc_q    <= '0;
            sp_q    <= '0;
            tgt_q   <= '0;
            i_q     <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (idle && arb.take) begin
                pc_q   <= pc_i;
                sp_q   <= sp_i;
                i_q    <= i_reg_i;
                kind_q <= arb.kind;
            end
            if (state_q == S_PUSH_L && mem_ack_i) begin
                case (kind_q)
                    K_NMI:   tgt_q <= NMI_VEC;
                    K_M0:    tgt_q <= pc_q;
                    default: tgt_q <= M1_VEC;
                endcase
            end
            if (state_q == S_RD_L && mem_ack_i) lo_q  <= mem_rdata_i;
            if (state_q == S_RD_H && mem_ack_i) tgt_q <= {mem_rdata_i, lo_q};
        end
    end

    assign busy_o    = !idle;
    assign pc_wr_o   = (state_q == S_FIN);
    assign pc_new_o  = tgt_q;
    assign sp_wr_o   = (state_q == S_FIN);
    assign sp_new_o  = sp_q - 16'd2;
    assign wz_wr_o   = (state_q == S_FIN) && (kind_q != K_NMI);
    assign wz_o      = tgt_q;
    assign op0_vld_o = (state_q == S_FIN) && (kind_q == K_M0);

    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R9
    ack_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(iack_o) |-> $past(boundary_i));

    // R3
    nmi_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PUSH_H && kind_q == K_NMI) |-> !iack_o);

    // R8
    fin_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pc_wr_o |=> !busy_o);

endmodule

// File: tb/irq_response_seq_tb.sv
module irq_response_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 0, skip_irq_i = 0, nmi_i = 0, int_i = 0, ie_i = 0;
    logic [1:0]  im_i = 0;
    logic [7:0]  i_reg_i = 0;
    logic [15:0] pc_i = 0, sp_i = 0;
    logic        halted_i = 0;
    logic [7:0]  dbus_i = 0;
    logic        dbus_vld_i = 0;
    logic        r_wr_i = 0;
    logic [7:0]  r_wdata_i = 0;
    logic [7:0]  mem_rdata_i;
    logic        mem_ack_i = 0;
    logic        busy_o, iack_o, ie_clr_o, halt_clr_o, halt_nop_o;
    logic        mem_req_o, mem_we_o, sp_wr_o, pc_wr_o, wz_wr_o, op0_vld_o;
    logic [15:0] mem_addr_o, sp_new_o, pc_new_o, wz_o;
    logic [7:0]  mem_wdata_o, r_o;
    logic [31:0] op0_bytes_o;

    always #4 clk = ~clk;

    irq_response_seq u_dut (.*);

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) mem_ack_i <= mem_req_o && !mem_ack_i;
    assign mem_rdata_i = memf(mem_addr_o);

    int checks = 0, fails = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor state
    int          n_iack, n_push, n_pcwr, dev_k, cur_nb;
    logic [7:0]  cur_db;
    logic [15:0] push_a [2];
    logic [7:0]  push_d [2];
    logic [15:0] pcv, spv, wzv;
    logic        wzw, opv;
    logic [31:0] opb;

    always @(negedge clk) begin
        if (iack_o) begin
            n_iack++;
            dbus_i     = cur_db + 8'(dev_k);
            dbus_vld_i = (dev_k < cur_nb);
            dev_k++;
        end else begin
            dbus_vld_i = 1'b0;
        end
        if (mem_req_o && mem_we_o && mem_ack_i) begin
            if (n_push < 2) begin
                push_a[n_push] = mem_addr_o;
                push_d[n_push] = mem_wdata_o;
            end
            n_push++;
        end
        if (pc_wr_o) begin
            n_pcwr++;
            pcv = pc_new_o; spv = sp_new_o; wzv = wz_o; wzw = wz_wr_o;
            opv = op0_vld_o; opb = op0_bytes_o;
        end
    end

    typedef struct packed {
        logic [1:0] im;
        logic       ie;
        logic       intr;
        logic       skip;
        logic       halt;
        logic       nmi;
        logic [2:0] nb;
        logic [7:0] db0;
        logic [7:0] ireg;
        logic [1:0] outc;   // 0 none, 1 nmi, 2 maskable
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 2'd2},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0},
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 8'h40, 8'h12, 2'd2},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h77, 8'h34, 2'd2},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 8'hFF, 8'hFF, 2'd2},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 8'hCD, 8'h00, 2'd2},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 8'h3E, 8'h00, 2'd2},
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 2'd2},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 2'd2},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 2'd1},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 2'd1},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 2'd2},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 8'h10, 8'h20, 2'd1}
    };

    task automatic run_vec(input int idx);
        vec_t        v;
        logic [15:0] pc, sp, exp_pc, p;
        logic [7:0]  b;
        logic [31:0] exp_ops;
        logic        s_ieclr, s_hclr, s_hnop;
        int          exp_ack;
        v  = VT[idx];
        pc = 16'h1000 + 16'(idx) * 16'h0111;
        sp = 16'hF000 - 16'(idx) * 16'h0010;
        @(negedge clk);
        pc_i = pc; sp_i = sp; im_i = v.im; ie_i = v.ie; int_i = v.intr;
        halted_i = v.halt; i_reg_i = v.ireg;
        cur_nb = int'(v.nb); cur_db = v.db0; dev_k = 0;
        n_iack = 0; n_push = 0; n_pcwr = 0;
        if (v.nmi) begin
            nmi_i = 1'b1;
            @(negedge clk);
            nmi_i = 1'b0;
        end
        @(negedge clk);
        boundary_i = 1'b1; skip_irq_i = v.skip;
        #1;
        s_ieclr = ie_clr_o; s_hclr = halt_clr_o; s_hnop = halt_nop_o;
        @(negedge clk);
        boundary_i = 1'b0; skip_irq_i = 1'b0;
        repeat (40) @(negedge clk);

        if (v.outc == 2'd0) begin
            // R2 R10: nothing taken
            chk(n_pcwr == 0 && n_push == 0, $sformatf("R2 vec%0d no action", idx), n_pcwr, 0);
            chk(s_ieclr == 1'b0, $sformatf("R2 vec%0d ie_clr", idx), s_ieclr, 0);
            chk(s_hnop == v.halt, $sformatf("R10 vec%0d halt_nop", idx), s_hnop, v.halt);
        end else begin
            if (v.outc == 2'd1) begin
                exp_pc = 16'h0066; exp_ack = 0;
            end else if (v.im == 2'd0) begin
                exp_pc = pc; exp_ack = 6;
            end else if (v.im == 2'd2) begin
                b = (v.nb != 0) ? v.db0 : 8'h00;
                p = {v.ireg, b};
                exp_pc = {memf(p + 16'd1), memf(p)}; exp_ack = 8;
            end else begin
                exp_pc = 16'h0038; exp_ack = 7;
            end
            chk(n_pcwr == 1 && pcv == exp_pc,
                $sformatf("R3/R5/R6 vec%0d new pc", idx), pcv, exp_pc);
            chk(spv == sp - 16'd2, $sformatf("R4 vec%0d sp", idx), spv, sp - 16'd2);
            chk(n_push == 2 && push_a[0] == sp - 16'd1 && push_d[0] == pc[15:8] &&
                push_a[1] == sp - 16'd2 && push_d[1] == pc[7:0],
                $sformatf("R4 vec%0d push order", idx), {push_a[0], push_d[0], push_d[1]},
                {sp - 16'd1, pc[15:8], pc[7:0]});
            chk(n_iack == exp_ack, $sformatf("R9 vec%0d ack cycles", idx), n_iack, exp_ack);
            chk(s_hclr == v.halt, $sformatf("R10 vec%0d halt_clr", idx), s_hclr, v.halt);
            if (v.outc == 2'd1) begin
                chk(!wzw && !s_ieclr, $sformatf("R3 vec%0d no wz/ie_clr", idx), {wzw, s_ieclr}, 0);
            end else begin
                chk(s_ieclr, $sformatf("R2 vec%0d ie_clr", idx), s_ieclr, 1);
                chk(wzw && wzv == exp_pc, $sformatf("R8 vec%0d wz", idx), wzv, exp_pc);
                if (v.im == 2'd0) begin
                    for (int k = 0; k < 4; k++)
                        exp_ops[k*8 +: 8] = (k < int'(v.nb)) ? v.db0 + 8'(k) : 8'h00;
                    chk(opv && opb == exp_ops, $sformatf("R7 vec%0d opcode bytes", idx), opb, exp_ops);
                end
            end
        end
    endtask

    task automatic r_step(input logic wr, input logic [7:0] wd, input logic bnd);
        @(negedge clk);
        r_wr_i = wr; r_wdata_i = wd; boundary_i = bnd;
        int_i = 1'b0; halted_i = 1'b0;
        @(negedge clk);
        r_wr_i = 1'b0; boundary_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy_o && !iack_o && !mem_req_o && !pc_wr_o && !sp_wr_o && !wz_wr_o && !op0_vld_o,
            "R1 reset outputs", {busy_o, iack_o, mem_req_o, pc_wr_o}, 0);
        chk(r_o == 8'h00, "R1 reset R", r_o, 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R11 refresh register
        r_step(1'b1, 8'hFF, 1'b0);
        r_step(1'b0, 8'h00, 1'b1);
        chk(r_o == 8'h80, "R11 bit7 kept on wrap", r_o, 8'h80);
        r_step(1'b1, 8'h7F, 1'b0);
        r_step(1'b0, 8'h00, 1'b1);
        chk(r_o == 8'h00, "R11 no carry into bit7", r_o, 8'h00);
        r_step(1'b1, 8'h10, 1'b1);
        chk(r_o == 8'h10, "R11 load wins", r_o, 8'h10);
        r_step(1'b0, 8'h00, 1'b1);
        r_step(1'b0, 8'h00, 1'b1);
        chk(r_o == 8'h12, "R11 two steps", r_o, 8'h12);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule